// File: doc/BRIEF.md
# Single-Cycle Word-Addressed RISC Core

This block is a small processor core that retires one instruction per clock from a single memory holding both program and data. Memory has 1024 words of 32 bits, and every address counts whole words. The core has 32 general registers of 32 bits. Register zero always reads as zero. Instruction fields follow the classic three-format layout: opcode in bits 31:26, rs in 25:21, rt in 20:16, rd in 15:11, shift amount in 10:6, function in 5:0, a 16-bit immediate in 15:0 and a 26-bit jump target in 25:0.

A host fills the memory through a write port while reset is held. It then releases reset, waits for the halt output and reads the results back through a registered read port. Branch offsets and jump targets are word quantities used without shifting. Control transfers act on the very next fetch, with no delay slot. An all-zero instruction word stops the machine until the next reset.

Top module: `mcore_top`

## Requirements
- R1: The host port writes `ld_data` to word `ld_addr` on a clock edge with `ld_we` high, and takes priority over a core store. `rd_data` shows the word at `rd_addr` one clock after the address is presented. A word keeps its value until it is overwritten.
- R2: While `rst` is high at a clock edge, the core clears the program counter to 0 and clears `halt_o`. It makes no register or memory updates during reset.
- R3: Register-register operations use opcode 0x00 with these function codes: 0x21 add, 0x23 subtract, 0x24 AND, 0x25 OR, 0x26 XOR, 0x27 NOR, 0x00 shift left logical of rt by shamt, 0x02 shift right logical, 0x03 shift right arithmetic. Opcode 0x1C with function 0x02 multiplies and keeps the low 32 bits. Results go to rd.
- R4: Immediate operations write rt. 0x09 adds the sign-extended immediate. 0x0A sets 1 when rs is less than the sign-extended immediate as signed values, and 0 otherwise. 0x0E XORs with the zero-extended immediate. 0x0F places the immediate in the upper 16 bits and zeros the lower 16.
- R5: Load (opcode 0x23) writes rt with the word at rs plus the sign-extended immediate. Store (opcode 0x2B) writes rt to that word at the retiring edge. Only the low 10 bits of the sum form the address, so addresses wrap modulo 1024.
- R6: beq (0x04), bne (0x05), blez (0x06) and bgtz (0x07) compare register values as signed numbers. When taken they set the PC to PC+1 plus the sign-extended offset; otherwise the PC advances by 1.
- R7: j (0x02) loads the PC from the target field. jal (0x03) does the same and writes PC+1 into r31. jr (function 0x08) loads the PC from rs. jalr (function 0x09) loads the PC from rs and writes PC+1 into rd.
- R8: An all-zero instruction word raises `halt_o` one clock after it is fetched. From then on the PC stays at the address of the halt word, and no register or memory update happens until reset.
- R9: Register zero reads as zero, and writes aimed at it are discarded.
- R10: Each clock retires exactly one instruction. A non-transfer instruction advances the PC by 1, so a program of N retired instructions followed by a halt raises `halt_o` N+1 clocks after reset is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_we | input | 1 | Host write enable for memory |
| ld_addr | input | 10 | Host write word address |
| ld_data | input | 32 | Host write data |
| rd_addr | input | 10 | Host read word address |
| rd_data | output | 32 | Registered host read data |
| pc_o | output | 10 | Current program counter |
| halt_o | output | 1 | Core has executed a halt word |

## Verification
Assertions watch, on every cycle, how the program counter moves: it clears on reset, steps by one for plain instructions, reaches the target after a jump or a taken branch, and holds together with a sticky halt flag once halted. The ALU results, the load and store effects, address wrap, the discarding of writes to register zero, link values and the total retired-instruction count can only be shown by running a program. The bench does this and reads the stored results back through the host port.

// File: rtl/mcore_pkg.sv
package mcore_pkg;

  localparam logic [5:0] OP_SPECIAL = 6'h00;
  localparam logic [5:0] OP_J       = 6'h02;
  localparam logic [5:0] OP_JAL     = 6'h03;
  localparam logic [5:0] OP_BEQ     = 6'h04;
  localparam logic [5:0] OP_BNE     = 6'h05;
  localparam logic [5:0] OP_BLEZ    = 6'h06;
  localparam logic [5:0] OP_BGTZ    = 6'h07;
  localparam logic [5:0] OP_ADDIU   = 6'h09;
  localparam logic [5:0] OP_SLTI    = 6'h0a;
  localparam logic [5:0] OP_XORI    = 6'h0e;
  localparam logic [5:0] OP_LUI     = 6'h0f;
  localparam logic [5:0] OP_MULOP   = 6'h1c;
  localparam logic [5:0] OP_LW      = 6'h23;
  localparam logic [5:0] OP_SW      = 6'h2b;

  localparam logic [5:0] FN_SLL  = 6'h00;
  localparam logic [5:0] FN_SRL  = 6'h02;
  localparam logic [5:0] FN_SRA  = 6'h03;
  localparam logic [5:0] FN_JR   = 6'h08;
  localparam logic [5:0] FN_JALR = 6'h09;
  localparam logic [5:0] FN_ADDU = 6'h21;
  localparam logic [5:0] FN_SUBU = 6'h23;
  localparam logic [5:0] FN_AND  = 6'h24;
  localparam logic [5:0] FN_OR   = 6'h25;
  localparam logic [5:0] FN_XOR  = 6'h26;
  localparam logic [5:0] FN_NOR  = 6'h27;
  localparam logic [5:0] FN_MUL  = 6'h02;

  typedef enum logic [3:0] {
    ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_XOR, ALU_NOR,
    ALU_SLL, ALU_SRL, ALU_SRA, ALU_SLT, ALU_LUI, ALU_MUL
  } alu_op_e;

  typedef enum logic [2:0] {BR_NONE, BR_EQ, BR_NE, BR_LEZ, BR_GTZ} br_kind_e;
  typedef enum logic [1:0] {DST_RD, DST_RT, DST_LINK} dst_e;
  typedef enum logic [1:0] {WB_ALU, WB_MEM, WB_LINK} wb_e;
  typedef enum logic [1:0] {PCS_SEQ, PCS_BR, PCS_JT, PCS_REG} pcs_e;

  typedef struct packed {
    alu_op_e  alu;
    logic     use_imm;
    logic     zext;
    logic     reg_we;
    dst_e     dst;
    wb_e      wb;
    logic     mem_we;
    br_kind_e br;
    pcs_e     pcs;
    logic     halt;
  } ctl_t;

endpackage

// File: rtl/mcore_decode.sv
module mcore_decode
  import mcore_pkg::*;
(
  input  logic [31:0] instr,
  output ctl_t        ctl
);

  logic [5:0] opc;
  logic [5:0] fn;

  assign opc = instr[31:26];
  assign fn  = instr[5:0];

  always_comb begin
    ctl = '{alu: ALU_ADD, use_imm: 1'b0, zext: 1'b0, reg_we: 1'b0,
            dst: DST_RD, wb: WB_ALU, mem_we: 1'b0, br: BR_NONE,
            pcs: PCS_SEQ, halt: 1'b0};
    if (instr == '0) begin
      ctl.halt = 1'b1;
    end else begin
      case (opc)
        OP_SPECIAL: begin
          ctl.reg_we = 1'b1;
          case (fn)
            FN_ADDU: ctl.alu = ALU_ADD;
            FN_SUBU: ctl.alu = ALU_SUB;
            FN_AND:  ctl.alu = ALU_AND;
            FN_OR:   ctl.alu = ALU_OR;
            FN_XOR:  ctl.alu = ALU_XOR;
            FN_NOR:  ctl.alu = ALU_NOR;
            FN_SLL:  ctl.alu = ALU_SLL;
            FN_SRL:  ctl.alu = ALU_SRL;
            FN_SRA:  ctl.alu = ALU_SRA;
            FN_JR: begin
              ctl.reg_we = 1'b0;
              ctl.pcs    = PCS_REG;
            end
            FN_JALR: begin
              ctl.wb  = WB_LINK;
              ctl.pcs = PCS_REG;
            end
            default: ctl.reg_we = 1'b0;
          endcase
        end
        OP_MULOP: begin
          if (fn == FN_MUL) begin
            ctl.alu    = ALU_MUL;
            ctl.reg_we = 1'b1;
          end
        end
        OP_ADDIU: begin
          ctl.use_imm = 1'b1; ctl.reg_we = 1'b1; ctl.dst = DST_RT;
        end
        OP_SLTI: begin
          ctl.alu = ALU_SLT; ctl.use_imm = 1'b1; ctl.reg_we = 1'b1; ctl.dst = DST_RT;
        end
        OP_XORI: begin
          ctl.alu = ALU_XOR; ctl.use_imm = 1'b1; ctl.zext = 1'b1;
          ctl.reg_we = 1'b1; ctl.dst = DST_RT;
        end
        OP_LUI: begin
          ctl.alu = ALU_LUI; ctl.use_imm = 1'b1; ctl.reg_we = 1'b1; ctl.dst = DST_RT;
        end
        OP_LW: begin
          ctl.use_imm = 1'b1; ctl.reg_we = 1'b1; ctl.dst = DST_RT; ctl.wb = WB_MEM;
        end
        OP_SW: begin
          ctl.use_imm = 1'b1; ctl.mem_we = 1'b1;
        end
        OP_BEQ:  begin ctl.br = BR_EQ;  ctl.pcs = PCS_BR; end
        OP_BNE:  begin ctl.br = BR_NE;  ctl.pcs = PCS_BR; end
        OP_BLEZ: begin ctl.br = BR_LEZ; ctl.pcs = PCS_BR; end
        OP_BGTZ: begin ctl.br = BR_GTZ; ctl.pcs = PCS_BR; end
        OP_J:    ctl.pcs = PCS_JT;
        OP_JAL: begin
          ctl.pcs = PCS_JT; ctl.reg_we = 1'b1; ctl.dst = DST_LINK; ctl.wb = WB_LINK;
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/mcore_regfile.sv
module mcore_regfile #(
  parameter int XLEN = 32,
  parameter int NREG = 32,
  localparam int RAW = $clog2(NREG)
) (
  input  logic            clk,
  input  logic [RAW-1:0]  ra1,
  input  logic [RAW-1:0]  ra2,
  output logic [XLEN-1:0] rd1,
  output logic [XLEN-1:0] rd2,
  input  logic            we,
  input  logic [RAW-1:0]  wa,
  input  logic [XLEN-1:0] wd
);

  logic [XLEN-1:0] regs [NREG];

  always_ff @(posedge clk) begin
    if (we && (wa != '0)) regs[wa] <= wd;
  end

  assign rd1 = (ra1 == '0) ? '0 : regs[ra1];
  assign rd2 = (ra2 == '0) ? '0 : regs[ra2];

endmodule

// File: rtl/mcore_alu.sv
module mcore_alu
  import mcore_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  alu_op_e         op,
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  input  logic [4:0]      shamt,
  output logic [XLEN-1:0] y
);

  logic [XLEN-1:0] prod;
  assign prod = a * b;

  always_comb begin
    case (op)
      ALU_ADD: y = a + b;
      ALU_SUB: y = a - b;
      ALU_AND: y = a & b;
      ALU_OR:  y = a | b;
      ALU_XOR: y = a ^ b;
      ALU_NOR: y = ~(a | b);
      ALU_SLL: y = b << shamt;
      ALU_SRL: y = b >> shamt;
      ALU_SRA: y = $signed(b) >>> shamt;
      ALU_SLT: y = ($signed(a) < $signed(b)) ? XLEN'(1) : '0;
      ALU_LUI: y = b << 16;
      ALU_MUL: y = prod;
      default: y = '0;
    endcase
  end

endmodule

// File: rtl/mcore_nextpc.sv
module mcore_nextpc
  import mcore_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int AW   = 10
) (
  input  logic [AW-1:0]   pc,
  input  pcs_e            pcs,
  input  br_kind_e        br,
  input  logic [XLEN-1:0] rs_val,
  input  logic [XLEN-1:0] rt_val,
  input  logic [XLEN-1:0] offs,
  input  logic [AW-1:0]   tgt,
  output logic [AW-1:0]   pc_inc,
  output logic [AW-1:0]   next_pc,
  output logic            taken
);

  logic rs_neg, rs_zero;

  assign pc_inc  = pc + AW'(1);
  assign rs_neg  = rs_val[XLEN-1];
  assign rs_zero = (rs_val == '0);

  always_comb begin
    case (br)
      BR_EQ:   taken = (rs_val == rt_val);
      BR_NE:   taken = (rs_val != rt_val);
      BR_LEZ:  taken = rs_neg || rs_zero;
      BR_GTZ:  taken = !rs_neg && !rs_zero;
      default: taken = 1'b0;
    endcase
  end

  always_comb begin
    case (pcs)
      PCS_BR:  next_pc = taken ? (pc_inc + offs[AW-1:0]) : pc_inc;
      PCS_JT:  next_pc = tgt;
      PCS_REG: next_pc = rs_val[AW-1:0];
      default: next_pc = pc_inc;
    endcase
  end

endmodule

// File: rtl/mcore_top.sv
module mcore_top
  import mcore_pkg::*;
#(
  parameter int XLEN      = 32,
  parameter int MEM_WORDS = 1024,
  parameter int NREG      = 32,
  localparam int AW       = $clog2(MEM_WORDS),
  localparam int RAW      = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            ld_we,
  input  logic [AW-1:0]   ld_addr,
  input  logic [XLEN-1:0] ld_data,
  input  logic [AW-1:0]   rd_addr,
  output logic [XLEN-1:0] rd_data,
  output logic [AW-1:0]   pc_o,
  output logic            halt_o
);

  logic [XLEN-1:0] mem [MEM_WORDS];

  logic [AW-1:0]   pc_q;
  logic            halted_q;
  logic [31:0]     instr;
  ctl_t            ctl;
  logic            run;

  logic [RAW-1:0]  rs_a, rt_a, rd_a, wa;
  logic [XLEN-1:0] rs_val, rt_val, imm_ext, alu_b, alu_y, wd, ld_word, link_val;
  logic [AW-1:0]   d_addr, pc_inc, next_pc;
  logic            taken, rf_we, st_we;

  assign instr = mem[pc_q];
  assign run   = !rst && !halted_q;

  mcore_decode u_dec (.instr(instr), .ctl(ctl));

  assign rs_a = instr[25:21];
  assign rt_a = instr[20:16];
  assign rd_a = instr[15:11];

  assign imm_ext = ctl.zext ? {{(XLEN-16){1'b0}}, instr[15:0]}
                            : {{(XLEN-16){instr[15]}}, instr[15:0]};
  assign alu_b   = ctl.use_imm ? imm_ext : rt_val;

  mcore_regfile #(.XLEN(XLEN), .NREG(NREG)) u_rf (
    .clk(clk), .ra1(rs_a), .ra2(rt_a), .rd1(rs_val), .rd2(rt_val),
    .we(rf_we), .wa(wa), .wd(wd)
  );

  mcore_alu #(.XLEN(XLEN)) u_alu (
    .op(ctl.alu), .a(rs_val), .b(alu_b), .shamt(instr[10:6]), .y(alu_y)
  );

  mcore_nextpc #(.XLEN(XLEN), .AW(AW)) u_npc (
    .pc(pc_q), .pcs(ctl.pcs), .br(ctl.br), .rs_val(rs_val), .rt_val(rt_val),
    .offs(imm_ext), .tgt(instr[AW-1:0]), .pc_inc(pc_inc), .next_pc(next_pc),
    .taken(taken)
  );

  assign d_addr   = alu_y[AW-1:0];
  assign ld_word  = mem[d_addr];
  assign link_val = XLEN'(pc_inc);

  always_comb begin
    case (ctl.dst)
      DST_RT:   wa = rt_a;
      DST_LINK: wa = RAW'(NREG - 1);
      default:  wa = rd_a;
    endcase
    case (ctl.wb)
      WB_MEM:  wd = ld_word;
      WB_LINK: wd = link_val;
      default: wd = alu_y;
    endcase
  end

  assign rf_we = run && ctl.reg_we && !ctl.halt;
  assign st_we = run && ctl.mem_we && !ctl.halt;

  always_ff @(posedge clk) begin
    if (ld_we)      mem[ld_addr] <= ld_data;
    else if (st_we) mem[d_addr]  <= rt_val;
    rd_data <= mem[rd_addr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q     <= '0;
      halted_q <= 1'b0;
    end else if (!halted_q) begin
      if (ctl.halt) halted_q <= 1'b1;
      else          pc_q     <= next_pc;
    end
  end

  assign pc_o   = pc_q;
  assign halt_o = halted_q;

  a_r2_reset_state: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (pc_q == '0) && !halted_q);

  a_r8_halt_hold: assert property (@(posedge clk) disable iff (rst)
    halted_q |=> halted_q && $stable(pc_q));

  a_r8_halt_entry: assert property (@(posedge clk) disable iff (rst)
    (!halted_q && ctl.halt) |=> halted_q && $stable(pc_q));

  a_r10_step: assert property (@(posedge clk) disable iff (rst)
    (!halted_q && !ctl.halt && ctl.pcs == PCS_SEQ) |=> pc_q == $past(pc_q) + AW'(1));

  a_r7_jump_target: assert property (@(posedge clk) disable iff (rst)
    (!halted_q && ctl.pcs == PCS_JT) |=> pc_q == $past(instr[AW-1:0]));

  a_r6_branch_taken: assert property (@(posedge clk) disable iff (rst)
    (!halted_q && ctl.pcs == PCS_BR && taken) |=>
      pc_q == $past(pc_q) + AW'(1) + $past(instr[AW-1:0]));

endmodule

// File: tb/tb_mcore_top.sv
module tb_mcore_top;

  localparam int AW = 10;
  localparam int NEXP = 24;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          ld_we = 1'b0;
  logic [AW-1:0] ld_addr = '0;
  logic [31:0]   ld_data = '0;
  logic [AW-1:0] rd_addr = '0;
  logic [31:0]   rd_data;
  logic [AW-1:0] pc_o;
  logic          halt_o;

  int checks = 0;
  int errs   = 0;
  logic [31:0] prog [128];

  always #2.5 clk = ~clk;

  mcore_top dut (
    .clk(clk), .rst(rst), .ld_we(ld_we), .ld_addr(ld_addr), .ld_data(ld_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .pc_o(pc_o), .halt_o(halt_o)
  );

  // expected memory words after the program: {address, value}
  localparam logic [41:0] EXPV [NEXP] = '{
    {10'd100, 32'h00000002}, {10'd101, 32'hfffffff8}, {10'd102, 32'h00000005},
    {10'd103, 32'hfffffffd}, {10'd104, 32'hfffffff8}, {10'd105, 32'h00000002},
    {10'd106, 32'h12340000}, {10'd107, 32'hffffff02}, {10'd108, 32'h00000001},
    {10'd109, 32'h00000000}, {10'd110, 32'h00000050}, {10'd111, 32'h0000000f},
    {10'd112, 32'hfffffffe}, {10'd113, 32'hfffffff1}, {10'd114, 32'h00000004},
    {10'd115, 32'h00000000}, {10'd116, 32'h00000002}, {10'd117, 32'h00000005},
    {10'd118, 32'h00000011}, {10'd119, 32'h00000036}, {10'd120, 32'h00000048},
    {10'd121, 32'h00000044}, {10'd122, 32'h00000006}, {10'd123, 32'h00000000}
  };
  localparam string EXPTAG [NEXP] = '{
    "R3 addu", "R3 subu", "R3 and", "R3 or", "R3 xor", "R3 nor",
    "R4 lui", "R4 xori", "R4 slti true", "R4 slti equal", "R3 sll", "R3 srl",
    "R3 sra", "R3 mul", "R5 lw", "R9 r0 write", "R5 lw wrap", "R5 sw wrap",
    "R6 branches", "R7 jal link", "R7 jalr link", "R7 jr return", "R6 loop", "R8 no store after halt"
  };

  function automatic logic [31:0] ri(int op, int rs, int rt, int imm);
    return {op[5:0], rs[4:0], rt[4:0], imm[15:0]};
  endfunction
  function automatic logic [31:0] rr(int op, int rs, int rt, int rd, int sh, int fn);
    return {op[5:0], rs[4:0], rt[4:0], rd[4:0], sh[4:0], fn[5:0]};
  endfunction
  function automatic logic [31:0] jt(int op, int tgt);
    return {op[5:0], tgt[25:0]};
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic read_word(input logic [AW-1:0] a, output logic [31:0] v);
    @(negedge clk); rd_addr = a;
    @(negedge clk); v = rd_data;
  endtask

  initial begin
    #1_000_000;
    errs++; checks++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    int cnt;
    logic [31:0] v;
    foreach (prog[i]) prog[i] = 32'h0;
    prog[0]  = ri(9, 0, 1, 5);
    prog[1]  = ri(9, 0, 2, -3);
    prog[2]  = rr(0, 1, 2, 3, 0, 'h21);
    prog[3]  = ri('h2b, 0, 3, 100);
    prog[4]  = rr(0, 2, 1, 4, 0, 'h23);
    prog[5]  = ri('h2b, 0, 4, 101);
    prog[6]  = rr(0, 1, 2, 5, 0, 'h24);
    prog[7]  = ri('h2b, 0, 5, 102);
    prog[8]  = rr(0, 1, 2, 6, 0, 'h25);
    prog[9]  = ri('h2b, 0, 6, 103);
    prog[10] = rr(0, 1, 2, 7, 0, 'h26);
    prog[11] = ri('h2b, 0, 7, 104);
    prog[12] = rr(0, 1, 2, 8, 0, 'h27);
    prog[13] = ri('h2b, 0, 8, 105);
    prog[14] = ri('h0f, 0, 9, 'h1234);
    prog[15] = ri('h2b, 0, 9, 106);
    prog[16] = ri('h0e, 2, 10, 'h00ff);
    prog[17] = ri('h2b, 0, 10, 107);
    prog[18] = ri('h0a, 2, 11, 1);
    prog[19] = ri('h2b, 0, 11, 108);
    prog[20] = ri('h0a, 1, 12, 5);
    prog[21] = ri('h2b, 0, 12, 109);
    prog[22] = rr(0, 0, 1, 13, 4, 'h00);
    prog[23] = ri('h2b, 0, 13, 110);
    prog[24] = rr(0, 0, 2, 14, 28, 'h02);
    prog[25] = ri('h2b, 0, 14, 111);
    prog[26] = rr(0, 0, 2, 15, 1, 'h03);
    prog[27] = ri('h2b, 0, 15, 112);
    prog[28] = rr('h1c, 1, 2, 16, 0, 'h02);
    prog[29] = ri('h2b, 0, 16, 113);
    prog[30] = ri('h23, 0, 17, 100);
    prog[31] = rr(0, 17, 17, 18, 0, 'h21);
    prog[32] = ri('h2b, 0, 18, 114);
    prog[33] = ri(9, 0, 0, 7);
    prog[34] = ri('h2b, 0, 0, 115);
    prog[35] = ri(9, 0, 19, 1000);
    prog[36] = ri('h23, 19, 20, 124);
    prog[37] = ri('h2b, 0, 20, 116);
    prog[38] = ri('h2b, 19, 1, 141);
    prog[39] = ri(4, 1, 1, 2);
    prog[40] = ri('h2b, 0, 1, 118);
    prog[41] = ri('h2b, 0, 1, 118);
    prog[42] = ri(5, 1, 1, 5);
    prog[43] = ri(9, 0, 21, 'h11);
    prog[44] = ri(7, 2, 0, 3);
    prog[45] = ri(6, 2, 0, 2);
    prog[46] = ri(9, 0, 21, 'h22);
    prog[47] = ri(9, 0, 21, 'h33);
    prog[48] = ri(7, 1, 0, 1);
    prog[49] = ri(9, 21, 21, 1);
    prog[50] = ri(6, 0, 0, 1);
    prog[51] = ri(9, 21, 21, 2);
    prog[52] = ri('h2b, 0, 21, 118);
    prog[53] = jt(3, 60);
    prog[54] = ri('h2b, 0, 31, 119);
    prog[55] = jt(2, 70);
    prog[60] = ri(9, 0, 22, 'h44);
    prog[61] = rr(0, 31, 0, 0, 0, 'h08);
    prog[70] = ri(9, 0, 23, 80);
    prog[71] = rr(0, 23, 0, 24, 0, 'h09);
    prog[80] = ri('h2b, 0, 24, 120);
    prog[81] = ri('h2b, 0, 22, 121);
    prog[82] = ri(9, 0, 25, 3);
    prog[83] = rr(0, 0, 0, 26, 0, 'h21);
    prog[84] = rr(0, 26, 25, 26, 0, 'h21);
    prog[85] = ri(9, 25, 25, -1);
    prog[86] = ri(7, 25, 0, -3);
    prog[87] = ri('h2b, 0, 26, 122);
    prog[88] = 32'h0;
    prog[89] = ri('h2b, 0, 1, 123);

    // load under reset
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check("R2 reset pc", 32'(pc_o), 32'h0);
    check("R2 reset halt", 32'(halt_o), 32'h0);
    for (int i = 0; i < 128; i++) begin
      @(negedge clk);
      ld_we = 1'b1; ld_addr = AW'(i); ld_data = prog[i];
    end
    @(negedge clk);
    ld_we = 1'b0;
    read_word(10'd3, v);
    check("R1 load readback", v, prog[3]);

    // run
    rst = 1'b0;
    cnt = 0;
    for (int k = 0; k < 500; k++) begin
      @(posedge clk);
      cnt++;
      @(negedge clk);
      if (halt_o) break;
    end
    check("R10 cycles to halt", 32'(cnt), 32'd69);
    check("R8 halt pc", 32'(pc_o), 32'd88);

    // expected result table
    for (int e = 0; e < NEXP; e++) begin
      read_word(EXPV[e][41:32], v);
      check(EXPTAG[e], v, EXPV[e][31:0]);
    end
    read_word(10'd0, v);
    check("R1 program word kept", v, prog[0]);

    // halt is sticky
    repeat (10) @(negedge clk);
    check("R8 halt sticky", 32'(halt_o), 32'h1);
    check("R8 pc held", 32'(pc_o), 32'd88);

    // host write while halted, then reset again
    @(negedge clk);
    ld_we = 1'b1; ld_addr = 10'd500; ld_data = 32'hcafe0001;
    @(negedge clk);
    ld_we = 1'b0;
    read_word(10'd500, v);
    check("R1 host write", v, 32'hcafe0001);
    rst = 1'b1;
    @(negedge clk);
    check("R2 re-reset halt", 32'(halt_o), 32'h0);
    check("R2 re-reset pc", 32'(pc_o), 32'h0);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule